// File: doc/BRIEF.md
# Parallel NOR flash geometry probe

This block interrogates a parallel NOR flash device over a simple strobed memory bus and recovers its self-describing geometry. When the host pulses `start_i`, the block does the following in order:

- resets the device and puts it into its query mode;
- confirms the three-character query signature;
- reads the command-set identifier, the write and erase timeout exponents, the size exponent and the number of erase-block regions;
- walks the region descriptors, storing the block count and block size of each region and the offset at which each region begins.

It then takes the device back out of query mode with the exit command that matches the discovered command set.

The device is accessed as a 16-bit part, so every command or query offset appears on the byte address bus shifted left by one bit. Each read holds its strobe for a programmable number of wait cycles before the returned byte is used, which covers slow device access times. The results stay on the output ports until the next probe starts. The host can use them directly to locate any block in the device.

Top module: `cfi_geom_probe`

## Requirements
- R1: Every bus access drives `fl_addr_o` equal to the query/command offset shifted left by one, so bit 0 is always zero.
- R2: A probe begins with two writes: 0xF0 at offset 0x00 (bus address 0x00), then 0x98 at offset 0x55 (bus address 0xAA). No read comes before them.
- R3: Offsets 0x10, 0x11 and 0x12 are read and must hold 0x51, 0x52 and 0x59 ("QRY"). On the first mismatch the probe ends with `err_nodev_o` set. After that mismatch it makes no further bus access and issues no exit command.
- R4: `cmdset_o` is the 16-bit little-endian value at offsets 0x13 (low byte) and 0x14 (high byte).
- R5: `wr_tmo_exp_o` is the 9-bit sum of the bytes at 0x1F and 0x23. `er_tmo_exp_o` is the 9-bit sum of the bytes at 0x21 and 0x25. `size_exp_o` is the byte at 0x27.
- R6: The region count is the byte at 0x2C. If it exceeds MAX_RGN (8), `err_regovf_o` is set and only MAX_RGN regions are walked. `region_cnt_o` shows the number of regions walked.
- R7: For region r, the 16-bit little-endian field at 0x2D+4r gives the block count minus one. The field at 0x2F+4r gives the block size divided by 256, with a zero field meaning 128 bytes. Each region's results appear in slice r of `rgn_blocks_o` and `rgn_bsize_o`.
- R8: Region 0 starts at offset 0. Each later region starts at the sum of block count times block size over all earlier regions. Slots beyond the walked count read zero.
- R9: The exit depends on the command set. For command set 2 the block writes 0xF0 then 0xFF at offset 0x00. For command sets 1 and 3 it writes only 0xFF. For any other value it writes nothing.
- R10: A read keeps `fl_req_o` high with a stable address for `rd_wait_i`+1 cycles and samples `fl_rdata_i` in the last of them. A write strobe lasts one cycle. Consecutive accesses are separated by at least one idle cycle.
- R11: `busy_o` rises the cycle after `start_i` and stays high until `done_o`, which pulses for one cycle. All results are cleared at start and held after done. No bus access happens while idle, and reset returns the block to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a probe (sampled while idle) |
| rd_wait_i | input | WAIT_W | Extra wait cycles per read |
| busy_o | output | 1 | Probe in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_nodev_o | output | 1 | Signature mismatch, no device |
| err_regovf_o | output | 1 | Region count exceeded MAX_RGN |
| cmdset_o | output | 16 | Command-set identifier |
| wr_tmo_exp_o | output | 9 | Write timeout exponent sum |
| er_tmo_exp_o | output | 9 | Erase timeout exponent sum |
| size_exp_o | output | 8 | log2 of device size in bytes |
| region_cnt_o | output | RCNT_W | Regions walked and stored |
| rgn_start_o | output | MAX_RGN*OFS_W | Region start offsets, slice r for region r |
| rgn_blocks_o | output | MAX_RGN*17 | Region block counts |
| rgn_bsize_o | output | MAX_RGN*24 | Region block sizes in bytes |
| fl_req_o | output | 1 | Flash access strobe |
| fl_we_o | output | 1 | Strobe is a write |
| fl_addr_o | output | ADDR_W | Flash byte address |
| fl_wdata_o | output | 8 | Write data |
| fl_rdata_i | input | 8 | Read data from flash |

## Verification
The probe is run against flash images that differ in the following ways:

- Command set: 2, 1 and 3, a value with a non-zero high byte, and an unknown value. These separate the three exit behaviours and show that both bytes of the identifier are assembled.
- Region count: zero, one, three, eight and twelve. These show the empty walk, the full walk and the clamp with its overflow flag.
- Descriptor fields: images with zero size fields and images whose exponent bytes sum past 255. These expose the 128-byte special case and a truncated timeout sum.
- Signature: a corrupted first character and a corrupted last character. The resulting read counts show that the probe stops at the failing byte.
- Read wait: values from 0 to 15. The flash model returns a garbage byte until the requested wait has elapsed, so a read sampled too early corrupts the captured values.

// File: rtl/cfi_probe_pkg.sv
package cfi_probe_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_FIN
  } st_e;

  typedef enum logic [2:0] {
    PH_ENTER,
    PH_SIG,
    PH_HDR,
    PH_RGN,
    PH_EXIT
  } ph_e;

  localparam logic [7:0] CMD_RST_A  = 8'hF0;
  localparam logic [7:0] CMD_RST_B  = 8'hFF;
  localparam logic [7:0] CMD_QUERY  = 8'h98;
  localparam logic [7:0] OFF_QUERY  = 8'h55;
  localparam logic [7:0] OFF_SIG    = 8'h10;
  localparam logic [7:0] OFF_RGN    = 8'h2D;

  localparam int BLK_W  = 17;
  localparam int BSZ_W  = 24;
  localparam int SPAN_W = BLK_W + BSZ_W;

  // header fields in the order they are captured
  function automatic logic [7:0] hdr_off(input logic [2:0] i);
    case (i)
      3'd0:    hdr_off = 8'h13;
      3'd1:    hdr_off = 8'h14;
      3'd2:    hdr_off = 8'h1F;
      3'd3:    hdr_off = 8'h23;
      3'd4:    hdr_off = 8'h21;
      3'd5:    hdr_off = 8'h25;
      3'd6:    hdr_off = 8'h27;
      default: hdr_off = 8'h2C;
    endcase
  endfunction

  function automatic logic [7:0] sig_char(input logic [1:0] i);
    case (i)
      2'd0:    sig_char = 8'h51;
      2'd1:    sig_char = 8'h52;
      default: sig_char = 8'h59;
    endcase
  endfunction

  function automatic logic [BSZ_W-1:0] bsize_dec(input logic [15:0] f);
    if (f == 16'd0) bsize_dec = BSZ_W'(128);
    else            bsize_dec = {f, 8'h00};
  endfunction

endpackage

// File: rtl/cfi_bus_port.sv
module cfi_bus_port #(
  parameter int ADDR_W = 9,
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_i,
  input  logic              we_i,
  input  logic [7:0]        off_i,
  input  logic [7:0]        wdata_i,
  input  logic [WAIT_W-1:0] wait_i,
  output logic              ack_o,
  output logic [7:0]        rdata_o,
  output logic              fl_req_o,
  output logic              fl_we_o,
  output logic [ADDR_W-1:0] fl_addr_o,
  output logic [7:0]        fl_wdata_o,
  input  logic [7:0]        fl_rdata_i
);

  logic              req_q, req_d;
  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        wd_q;
  logic [WAIT_W-1:0] lim_q;
  logic [WAIT_W-1:0] cnt_q, cnt_d;
  logic              last;

  assign last = req_q && (we_q || (cnt_q == lim_q));

  always_comb begin
    req_d = req_q;
    cnt_d = cnt_q;
    if (go_i) begin
      req_d = 1'b1;
      cnt_d = '0;
    end else if (last) begin
      req_d = 1'b0;
      cnt_d = '0;
    end else if (req_q) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      req_q <= req_d;
      cnt_q <= cnt_d;
    end
  end

  // payload registers load only when a new access is launched
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q   <= 1'b0;
      addr_q <= '0;
      wd_q   <= '0;
      lim_q  <= '0;
    end else if (go_i) begin
      we_q   <= we_i;
      addr_q <= ADDR_W'({off_i, 1'b0});
      wd_q   <= wdata_i;
      lim_q  <= wait_i;
    end
  end

  assign ack_o      = last;
  assign rdata_o    = fl_rdata_i;
  assign fl_req_o   = req_q;
  assign fl_we_o    = we_q;
  assign fl_addr_o  = addr_q;
  assign fl_wdata_o = wd_q;

  AST_ADDR_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    fl_req_o |-> (fl_addr_o[0] == 1'b0)); // R1
  AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_req_o && fl_we_o) |=> !fl_req_o); // R10
  AST_RD_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_req_o && !fl_we_o && !ack_o) |=> (fl_req_o && $stable(fl_addr_o))); // R10
  AST_NO_LAUNCH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    go_i |-> !fl_req_o); // R10

endmodule

// File: rtl/cfi_region_acc.sv
module cfi_region_acc
  import cfi_probe_pkg::*;
#(
  parameter int MAX_RGN = 8,
  parameter int OFS_W   = 44,
  localparam int RIDX_W = $clog2(MAX_RGN)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr_i,
  input  logic                     commit_i,
  input  logic [RIDX_W-1:0]        idx_i,
  input  logic [15:0]              cnt_fld_i,
  input  logic [15:0]              sz_fld_i,
  output logic [MAX_RGN*OFS_W-1:0] start_o,
  output logic [MAX_RGN*BLK_W-1:0] blocks_o,
  output logic [MAX_RGN*BSZ_W-1:0] bsize_o
);

  logic [BLK_W-1:0]  blocks_d;
  logic [BSZ_W-1:0]  bsize_d;
  logic [SPAN_W-1:0] span;
  logic [OFS_W-1:0]  acc_q;

  assign blocks_d = BLK_W'(cnt_fld_i) + BLK_W'(1);
  assign bsize_d  = bsize_dec(sz_fld_i);
  assign span     = SPAN_W'(blocks_d) * SPAN_W'(bsize_d);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        acc_q <= '0;
    else if (clr_i)    acc_q <= '0;
    else if (commit_i) acc_q <= acc_q + OFS_W'(span);
  end

  for (genvar g = 0; g < MAX_RGN; g++) begin : g_slot
    logic [OFS_W-1:0] st_q;
    logic [BLK_W-1:0] bl_q;
    logic [BSZ_W-1:0] bs_q;
    logic             hit;

    assign hit = commit_i && (idx_i == RIDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q <= '0;
        bl_q <= '0;
        bs_q <= '0;
      end else if (clr_i) begin
        st_q <= '0;
        bl_q <= '0;
        bs_q <= '0;
      end else if (hit) begin
        st_q <= acc_q;
        bl_q <= blocks_d;
        bs_q <= bsize_d;
      end
    end

    assign start_o[g*OFS_W +: OFS_W]  = st_q;
    assign blocks_o[g*BLK_W +: BLK_W] = bl_q;
    assign bsize_o[g*BSZ_W +: BSZ_W]  = bs_q;
  end

  AST_ACC_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    commit_i |=> (acc_q > $past(acc_q))); // R8
  AST_SLOT0_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && idx_i == '0) |-> (acc_q == '0)); // R8

endmodule

// File: rtl/cfi_geom_probe.sv
module cfi_geom_probe
  import cfi_probe_pkg::*;
#(
  parameter int MAX_RGN = 8,
  parameter int OFS_W   = 44,
  parameter int ADDR_W  = 9,
  parameter int WAIT_W  = 4,
  localparam int RIDX_W = $clog2(MAX_RGN),
  localparam int RCNT_W = $clog2(MAX_RGN + 1),
  localparam int STEP_W = RIDX_W + 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic [WAIT_W-1:0]        rd_wait_i,
  output logic                     busy_o,
  output logic                     done_o,
  output logic                     err_nodev_o,
  output logic                     err_regovf_o,
  output logic [15:0]              cmdset_o,
  output logic [8:0]               wr_tmo_exp_o,
  output logic [8:0]               er_tmo_exp_o,
  output logic [7:0]               size_exp_o,
  output logic [RCNT_W-1:0]        region_cnt_o,
  output logic [MAX_RGN*OFS_W-1:0] rgn_start_o,
  output logic [MAX_RGN*BLK_W-1:0] rgn_blocks_o,
  output logic [MAX_RGN*BSZ_W-1:0] rgn_bsize_o,
  output logic                     fl_req_o,
  output logic                     fl_we_o,
  output logic [ADDR_W-1:0]        fl_addr_o,
  output logic [7:0]               fl_wdata_o,
  input  logic [7:0]               fl_rdata_i
);

  st_e               st_q, st_d;
  ph_e               ph_q, ph_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic [15:0]       cs_q, cs_d;
  logic [8:0]        wexp_q, wexp_d, eexp_q, eexp_d;
  logic [7:0]        sexp_q, sexp_d;
  logic [RCNT_W-1:0] rcnt_q, rcnt_d;
  logic              nodev_q, nodev_d, ovf_q, ovf_d;
  logic [23:0]       fld_q, fld_d;

  logic              go, ack, commit, acc_clr, to_exit;
  logic              cmd_we;
  logic [7:0]        cmd_off, cmd_wd, rdata;
  logic [RIDX_W-1:0] ridx;
  logic              cs_dual, cs_single, rgn_last;

  assign ridx      = step_q[STEP_W-1:2];
  assign cs_dual   = (cs_q == 16'd2);
  assign cs_single = (cs_q == 16'd1) || (cs_q == 16'd3);
  assign rgn_last  = (RCNT_W'(ridx) + RCNT_W'(1)) == rcnt_q;

  // command decode from phase and step
  always_comb begin
    cmd_we  = 1'b0;
    cmd_off = 8'h00;
    cmd_wd  = 8'h00;
    case (ph_q)
      PH_ENTER: begin
        cmd_we  = 1'b1;
        cmd_off = step_q[0] ? OFF_QUERY : 8'h00;
        cmd_wd  = step_q[0] ? CMD_QUERY : CMD_RST_A;
      end
      PH_SIG:  cmd_off = OFF_SIG + 8'(step_q[1:0]);
      PH_HDR:  cmd_off = hdr_off(step_q[2:0]);
      PH_RGN:  cmd_off = OFF_RGN + 8'(step_q);
      PH_EXIT: begin
        cmd_we  = 1'b1;
        cmd_off = 8'h00;
        cmd_wd  = step_q[0] ? CMD_RST_B : CMD_RST_A;
      end
      default: ;
    endcase
  end

  // sequencer next state
  always_comb begin
    st_d    = st_q;
    ph_d    = ph_q;
    step_d  = step_q;
    cs_d    = cs_q;
    wexp_d  = wexp_q;
    eexp_d  = eexp_q;
    sexp_d  = sexp_q;
    rcnt_d  = rcnt_q;
    nodev_d = nodev_q;
    ovf_d   = ovf_q;
    fld_d   = fld_q;
    go      = 1'b0;
    commit  = 1'b0;
    acc_clr = 1'b0;
    to_exit = 1'b0;
    case (st_q)
      ST_IDLE: if (start_i) begin
        st_d    = ST_ISSUE;
        ph_d    = PH_ENTER;
        step_d  = '0;
        cs_d    = '0;
        wexp_d  = '0;
        eexp_d  = '0;
        sexp_d  = '0;
        rcnt_d  = '0;
        nodev_d = 1'b0;
        ovf_d   = 1'b0;
        acc_clr = 1'b1;
      end
      ST_ISSUE: begin
        go   = 1'b1;
        st_d = ST_WAIT;
      end
      ST_WAIT: if (ack) begin
        st_d   = ST_ISSUE;
        step_d = step_q + 1'b1;
        case (ph_q)
          PH_ENTER: if (step_q[0]) begin
            ph_d   = PH_SIG;
            step_d = '0;
          end
          PH_SIG: begin
            if (rdata != sig_char(step_q[1:0])) begin
              nodev_d = 1'b1;
              st_d    = ST_FIN;
            end else if (step_q[1:0] == 2'd2) begin
              ph_d   = PH_HDR;
              step_d = '0;
            end
          end
          PH_HDR: begin
            case (step_q[2:0])
              3'd0: cs_d[7:0]  = rdata;
              3'd1: cs_d[15:8] = rdata;
              3'd2: wexp_d     = {1'b0, rdata};
              3'd3: wexp_d     = wexp_q + {1'b0, rdata};
              3'd4: eexp_d     = {1'b0, rdata};
              3'd5: eexp_d     = eexp_q + {1'b0, rdata};
              3'd6: sexp_d     = rdata;
              default: begin
                if (int'(rdata) > MAX_RGN) begin
                  ovf_d  = 1'b1;
                  rcnt_d = RCNT_W'(MAX_RGN);
                end else begin
                  rcnt_d = RCNT_W'(rdata);
                end
                if (rdata == 8'd0) begin
                  to_exit = 1'b1;
                end else begin
                  ph_d   = PH_RGN;
                  step_d = '0;
                end
              end
            endcase
          end
          PH_RGN: begin
            case (step_q[1:0])
              2'd0: fld_d[7:0]   = rdata;
              2'd1: fld_d[15:8]  = rdata;
              2'd2: fld_d[23:16] = rdata;
              default: begin
                commit = 1'b1;
                if (rgn_last) to_exit = 1'b1;
              end
            endcase
          end
          PH_EXIT: if (step_q[0]) st_d = ST_FIN;
          default: ;
        endcase
        if (to_exit) begin
          if (cs_dual) begin
            ph_d   = PH_EXIT;
            step_d = '0;
          end else if (cs_single) begin
            ph_d   = PH_EXIT;
            step_d = STEP_W'(1);
          end else begin
            st_d = ST_FIN;
          end
        end
      end
      ST_FIN:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      ph_q    <= PH_ENTER;
      step_q  <= '0;
      cs_q    <= '0;
      wexp_q  <= '0;
      eexp_q  <= '0;
      sexp_q  <= '0;
      rcnt_q  <= '0;
      nodev_q <= 1'b0;
      ovf_q   <= 1'b0;
      fld_q   <= '0;
    end else begin
      st_q    <= st_d;
      ph_q    <= ph_d;
      step_q  <= step_d;
      cs_q    <= cs_d;
      wexp_q  <= wexp_d;
      eexp_q  <= eexp_d;
      sexp_q  <= sexp_d;
      rcnt_q  <= rcnt_d;
      nodev_q <= nodev_d;
      ovf_q   <= ovf_d;
      fld_q   <= fld_d;
    end
  end

  cfi_bus_port #(
    .ADDR_W (ADDR_W),
    .WAIT_W (WAIT_W)
  ) bus_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .go_i       (go),
    .we_i       (cmd_we),
    .off_i      (cmd_off),
    .wdata_i    (cmd_wd),
    .wait_i     (rd_wait_i),
    .ack_o      (ack),
    .rdata_o    (rdata),
    .fl_req_o   (fl_req_o),
    .fl_we_o    (fl_we_o),
    .fl_addr_o  (fl_addr_o),
    .fl_wdata_o (fl_wdata_o),
    .fl_rdata_i (fl_rdata_i)
  );

  cfi_region_acc #(
    .MAX_RGN (MAX_RGN),
    .OFS_W   (OFS_W)
  ) acc_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (acc_clr),
    .commit_i  (commit),
    .idx_i     (ridx),
    .cnt_fld_i (fld_q[15:0]),
    .sz_fld_i  ({rdata, fld_q[23:16]}),
    .start_o   (rgn_start_o),
    .blocks_o  (rgn_blocks_o),
    .bsize_o   (rgn_bsize_o)
  );

  assign busy_o       = (st_q != ST_IDLE);
  assign done_o       = (st_q == ST_FIN);
  assign err_nodev_o  = nodev_q;
  assign err_regovf_o = ovf_q;
  assign cmdset_o     = cs_q;
  assign wr_tmo_exp_o = wexp_q;
  assign er_tmo_exp_o = eexp_q;
  assign size_exp_o   = sexp_q;
  assign region_cnt_o = rcnt_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !fl_req_o); // R11
  AST_RCNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    int'(region_cnt_o) <= MAX_RGN); // R6
  AST_OVF_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    err_regovf_o |-> (int'(region_cnt_o) == MAX_RGN)); // R6
  AST_NODEV_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_nodev_o) |-> !fl_req_o); // R3
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o); // R11

endmodule

// File: tb/cfi_geom_probe_tb.sv
module cfi_geom_probe_tb_top;

  localparam int CLK_P   = 10;
  localparam int MAX_RGN = 8;
  localparam int OFS_W   = 44;
  localparam int RCNT_W  = $clog2(MAX_RGN + 1);
  localparam int NVEC    = 8;

  typedef struct packed {
    logic [3:0]  wt;
    logic [1:0]  bad;
    logic [15:0] cs;
    logic [7:0]  nr;
    logic [7:0]  seed;
  } vec_t;

  // wait, corrupted signature byte (0 = none), command set, region count, seed
  localparam logic [37:0] VECS [NVEC] = '{
    {4'd0, 2'd0, 16'h0002, 8'd3,  8'h11},
    {4'd3, 2'd0, 16'h0001, 8'd8,  8'h42},
    {4'd5, 2'd0, 16'h0003, 8'd1,  8'h00},
    {4'd2, 2'd0, 16'h0004, 8'd0,  8'h37},
    {4'd1, 2'd0, 16'h0002, 8'd12, 8'h9C},
    {4'd2, 2'd1, 16'h0002, 8'd3,  8'h11},
    {4'd0, 2'd3, 16'h0001, 8'd2,  8'h22},
    {4'd7, 2'd0, 16'h0102, 8'd2,  8'hC3}
  };

  logic clk, rst_n, start;
  logic [3:0] wait_cur;
  logic busy, done, nodev, ovf;
  logic [15:0] cs;
  logic [8:0] wexp, eexp;
  logic [7:0] sexp;
  logic [RCNT_W-1:0] rcnt;
  logic [MAX_RGN*OFS_W-1:0] rstart;
  logic [MAX_RGN*17-1:0] rblocks;
  logic [MAX_RGN*24-1:0] rbsize;
  logic fl_req, fl_we;
  logic [8:0] fl_addr;
  logic [7:0] fl_wdata, fl_rdata;

  logic [7:0] mem [128];
  logic [7:0] age;
  logic log_clr;
  logic [7:0] wl_a [16];
  logic [7:0] wl_d [16];
  int wcnt, rdcnt;
  logic odd_seen;

  int n_chk = 0;
  int n_fail = 0;

  cfi_geom_probe #(.MAX_RGN(MAX_RGN), .OFS_W(OFS_W), .ADDR_W(9), .WAIT_W(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .rd_wait_i(wait_cur),
    .busy_o(busy), .done_o(done), .err_nodev_o(nodev), .err_regovf_o(ovf),
    .cmdset_o(cs), .wr_tmo_exp_o(wexp), .er_tmo_exp_o(eexp), .size_exp_o(sexp),
    .region_cnt_o(rcnt), .rgn_start_o(rstart), .rgn_blocks_o(rblocks), .rgn_bsize_o(rbsize),
    .fl_req_o(fl_req), .fl_we_o(fl_we), .fl_addr_o(fl_addr), .fl_wdata_o(fl_wdata),
    .fl_rdata_i(fl_rdata)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  // flash model: returns garbage until the requested wait has elapsed
  assign fl_rdata = (fl_req && !fl_we && age >= {4'b0, wait_cur}) ? mem[fl_addr[7:1]] : 8'h5A;

  always @(posedge clk) begin
    if (fl_req && !fl_we) age <= (age == 8'hFF) ? age : age + 8'd1;
    else                  age <= 8'd0;
  end

  always @(posedge clk) begin
    if (log_clr) begin
      wcnt <= 0; rdcnt <= 0; odd_seen <= 1'b0;
    end else begin
      if (fl_req && fl_we) begin
        wl_a[wcnt[3:0]] <= fl_addr[7:0];
        wl_d[wcnt[3:0]] <= fl_wdata;
        wcnt <= wcnt + 1;
      end
      if (fl_req && !fl_we && age == 8'd0) rdcnt <= rdcnt + 1;
      if (fl_req && fl_addr[0]) odd_seen <= 1'b1;
    end
  end

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic logic [15:0] cnt_f(input logic [7:0] seed, input int r);
    cnt_f = {8'(seed + 8'(r)), 8'(seed * 8'd3 + 8'(r * 29))};
  endfunction

  function automatic logic [15:0] sz_f(input logic [7:0] seed, input int r);
    if (((r + int'(seed)) % 3) == 0) sz_f = 16'd0;
    else sz_f = {7'd0, 1'(r), 8'(seed + 8'(r * 13) + 8'd1)};
  endfunction

  task automatic load_mem(input vec_t v);
    for (int i = 0; i < 128; i++) mem[i] = 8'hEE;
    mem[8'h10] = (v.bad == 2'd1) ? 8'h71 : 8'h51;
    mem[8'h11] = (v.bad == 2'd2) ? 8'h72 : 8'h52;
    mem[8'h12] = (v.bad == 2'd3) ? 8'h79 : 8'h59;
    mem[8'h13] = v.cs[7:0];
    mem[8'h14] = v.cs[15:8];
    mem[8'h1F] = v.seed;
    mem[8'h23] = v.seed ^ 8'hA5;
    mem[8'h21] = 8'd9 + {4'd0, v.seed[3:0]};
    mem[8'h25] = 8'h0C;
    mem[8'h27] = 8'd16 + {5'd0, v.seed[2:0]};
    mem[8'h2C] = v.nr;
    for (int r = 0; r < 8; r++) begin
      logic [15:0] c, s;
      c = cnt_f(v.seed, r);
      s = sz_f(v.seed, r);
      mem[8'h2D + 4*r]     = c[7:0];
      mem[8'h2D + 4*r + 1] = c[15:8];
      mem[8'h2D + 4*r + 2] = s[7:0];
      mem[8'h2D + 4*r + 3] = s[15:8];
    end
  endtask

  task automatic run_vec(input vec_t v, input int vi);
    int cyc;
    int nst;
    int ne;
    logic [7:0] ea [4];
    logic [7:0] ed [4];
    longint acc;
    wait_cur = v.wt;
    load_mem(v);
    @(negedge clk) log_clr = 1'b1;
    @(negedge clk) begin log_clr = 1'b0; start = 1'b1; end
    @(negedge clk) start = 1'b0;
    chk($sformatf("R11 v%0d busy after start", vi), 64'(busy), 64'd1);
    cyc = 0;
    while (!done && cyc < 5000) begin @(negedge clk); cyc++; end
    chk($sformatf("R11 v%0d done seen", vi), 64'(done), 64'd1);
    // results valid while done is high
    if (v.bad != 2'd0) begin
      chk($sformatf("R3 v%0d nodev", vi), 64'(nodev), 64'd1);
      chk($sformatf("R3 v%0d reads", vi), 64'(rdcnt), 64'(v.bad));
      chk($sformatf("R11 v%0d cmdset cleared", vi), 64'(cs), 64'd0);
      ne = 2;
    end else begin
      nst = (v.nr > 8) ? 8 : int'(v.nr);
      chk($sformatf("R3 v%0d nodev", vi), 64'(nodev), 64'd0);
      chk($sformatf("R4 v%0d cmdset", vi), 64'(cs), 64'(v.cs));
      chk($sformatf("R5 v%0d write exp", vi), 64'(wexp), 64'({1'b0, v.seed} + {1'b0, v.seed ^ 8'hA5}));
      chk($sformatf("R5 v%0d erase exp", vi), 64'(eexp), 64'(9 + int'(v.seed[3:0]) + 12));
      chk($sformatf("R5 v%0d size exp", vi), 64'(sexp), 64'(16 + int'(v.seed[2:0])));
      chk($sformatf("R6 v%0d region count", vi), 64'(rcnt), 64'(nst));
      chk($sformatf("R6 v%0d overflow", vi), 64'(ovf), 64'(v.nr > 8));
      chk($sformatf("R10 v%0d reads", vi), 64'(rdcnt), 64'(11 + 4*nst));
      acc = 0;
      for (int r = 0; r < 8; r++) begin
        longint bl, bs;
        logic [15:0] s;
        s  = sz_f(v.seed, r);
        bl = longint'(cnt_f(v.seed, r)) + 1;
        bs = (s == 16'd0) ? 128 : longint'(s) * 256;
        if (r < nst) begin
          chk($sformatf("R8 v%0d r%0d start", vi, r), 64'(rstart[r*OFS_W +: OFS_W]), 64'(acc));
          chk($sformatf("R7 v%0d r%0d blocks", vi, r), 64'(rblocks[r*17 +: 17]), 64'(bl));
          chk($sformatf("R7 v%0d r%0d bsize", vi, r), 64'(rbsize[r*24 +: 24]), 64'(bs));
          acc = acc + bl * bs;
        end else begin
          chk($sformatf("R8 v%0d r%0d unused slot", vi, r),
              64'(rstart[r*OFS_W +: OFS_W]) | 64'(rblocks[r*17 +: 17]) | 64'(rbsize[r*24 +: 24]), 64'd0);
        end
      end
      ne = 2;
      if (v.cs == 16'd2) begin
        ea[2] = 8'h00; ed[2] = 8'hF0; ea[3] = 8'h00; ed[3] = 8'hFF; ne = 4;
      end else if (v.cs == 16'd1 || v.cs == 16'd3) begin
        ea[2] = 8'h00; ed[2] = 8'hFF; ne = 3;
      end
    end
    ea[0] = 8'h00; ed[0] = 8'hF0; ea[1] = 8'hAA; ed[1] = 8'h98;
    chk($sformatf("R9 v%0d write count", vi), 64'(wcnt), 64'(ne));
    for (int k = 0; k < ne; k++) begin
      chk($sformatf("R2 R9 v%0d write %0d addr", vi, k), 64'(wl_a[k]), 64'(ea[k]));
      chk($sformatf("R2 R9 v%0d write %0d data", vi, k), 64'(wl_d[k]), 64'(ed[k]));
    end
    chk($sformatf("R1 v%0d odd address", vi), 64'(odd_seen), 64'd0);
    @(negedge clk);
    chk($sformatf("R11 v%0d done one cycle", vi), 64'(done), 64'd0);
    chk($sformatf("R11 v%0d idle after", vi), 64'(busy), 64'd0);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_fail++;
    $display("FAIL R11 watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; wait_cur = 4'd0; log_clr = 1'b1; age = 8'd0;
    for (int i = 0; i < 128; i++) mem[i] = 8'hEE;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 reset busy", 64'(busy), 64'd0);
    chk("R11 reset done", 64'(done), 64'd0);
    chk("R11 reset strobe", 64'(fl_req), 64'd0);
    chk("R3 reset nodev", 64'(nodev), 64'd0);
    chk("R6 reset count", 64'(rcnt), 64'd0);

    for (int i = 0; i < NVEC; i++) run_vec(vec_t'(VECS[i]), i);

    // maximum wait with the full region walk
    run_vec(vec_t'({4'd15, 2'd0, 16'h0003, 8'd8, 8'h5D}), 100);
    // middle signature byte corrupted
    run_vec(vec_t'({4'd4, 2'd2, 16'h0002, 8'd1, 8'h01}), 101);

    // reset during a probe returns to idle
    wait_cur = 4'd6;
    load_mem(vec_t'({4'd6, 2'd0, 16'h0002, 8'd8, 8'h10}));
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (40) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R11 mid reset busy", 64'(busy), 64'd0);
    chk("R11 mid reset strobe", 64'(fl_req), 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run_vec(vec_t'(VECS[0]), 102);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule